// File: doc/BRIEF.md
# Numerically Controlled Sine Oscillator

This block produces a digital sine wave for an external DAC. On every clock it adds a frequency word to a 32-bit phase register. The register wraps, so the output frequency is the word times the clock rate divided by 2^32. A 14-bit phase offset is added to the upper part of that phase. The sum is then cut to 12 bits. Those 12 bits are turned into a signed amplitude through a folded quarter-wave table. A gain factor scales the amplitude before it is registered onto the output.

The frequency word, the offset and the gain are written into holding registers through their own load strobes. A single commit pulse moves all three into the working registers on the same clock edge. A phase-zero input restarts the wave from phase zero and leaves every setting in place.

Top module: `nco_core`

## Requirements
- R1: Each clock the 32-bit phase register advances by the working frequency word, modulo 2^32.
- R2: Loaded values sit in holding registers and have no effect on the output until `commit` is high. A commit copies all three settings on one edge, and a load in that same cycle takes part in the copy.
- R3: The working offset is added, modulo 2^14, to phase bits [31:18]. Bits [13:2] of that sum form the 12-bit table phase, and the low bits are discarded.
- R4: Table phase bits [11:10] give the quadrant and bits [9:0] give the index a. Quadrants 1 and 3 use the mirrored index 1023-a. Quadrants 2 and 3 negate the sample. The magnitude is within one step of round(511·sin(π/2·(a+0.5)/1024)).
- R5: The output is floor(sample·G/512), where G is the working gain. A gain loaded above 512 is taken as 512.
- R6: A synchronous reset clears the phase, the holding and working registers and the pipeline, so the output reads 0 and stays 0 until settings are committed.
- R7: `phase_zero` sets the phase register to 0 on the next edge and keeps the frequency word, the offset and the gain.
- R8: After a commit edge, a new frequency word first changes the output 4 edges later. A new offset or a new gain first changes it 3 edges later.
- R9: With a frequency word of 2^k, the output repeats exactly every 2^(32-k) clocks, and half a period later it is exactly the negated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_load | input | 1 | Write `freq_word` into its holding register |
| freq_word | input | 32 | Frequency tuning word |
| offs_load | input | 1 | Write `offs_word` into its holding register |
| offs_word | input | 14 | Phase offset |
| gain_load | input | 1 | Write `gain_word` into its holding register |
| gain_word | input | 10 | Gain factor, where 512 means unity |
| commit | input | 1 | Copy all holding registers to the working registers |
| phase_zero | input | 1 | Reset the phase register to zero |
| dac_out | output | 10 | Signed two's-complement sample |

## Verification
An output seen after edge k is a function of the phase, offset and gain as they stood after edge k-3. The bench keeps its own phase model and a three-deep history of these values, and it compares each output with the entry from three edges earlier. The allowance is two steps, to cover table rounding. Latency is measured directly. The bench sets a commit, then counts edges to the first output change and expects 4 for a frequency word and 3 for an offset or a gain. The period test compares samples 64 and 32 clocks apart, taken only after the pipeline has filled.

// File: rtl/nco_pkg.sv
package nco_pkg;

   // Quarter-wave magnitude for table entry idx of 2**aw entries, peak 2**mw-1.
   // Rational sine approximation over the half wave, evaluated at entry centres.
   function automatic longint qsine(input int idx, input int aw, input int mw);
      longint len, t, prod, num, den, peak;
      len  = longint'(4) << aw;
      t    = 2 * longint'(idx) + 1;
      prod = t * (len - t);
      peak = (longint'(1) << mw) - 1;
      num  = 16 * prod * peak;
      den  = 5 * len * len - 4 * prod;
      return (num + den / 2) / den;
   endfunction

   function automatic logic [31:0] clamp_gain(input logic [31:0] g, input int unity);
      return (g > 32'(unity)) ? 32'(unity) : g;
   endfunction

endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl #(
   parameter int ACC_W = 32,
   parameter int OFS_W = 14,
   parameter int GAIN_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              freq_load,
   input  logic [ACC_W-1:0]  freq_word,
   input  logic              offs_load,
   input  logic [OFS_W-1:0]  offs_word,
   input  logic              gain_load,
   input  logic [GAIN_W-1:0] gain_word,
   input  logic              commit,
   output logic [ACC_W-1:0]  freq_act,
   output logic [OFS_W-1:0]  offs_act,
   output logic [GAIN_W-1:0] gain_act
);
   import nco_pkg::*;

   localparam int UNITY = 1 << (GAIN_W - 1);

   logic [ACC_W-1:0]  freq_hold, freq_nxt;
   logic [OFS_W-1:0]  offs_hold, offs_nxt;
   logic [GAIN_W-1:0] gain_hold, gain_nxt, gain_lim;

   always_comb begin
      freq_nxt = freq_load ? freq_word : freq_hold;
      offs_nxt = offs_load ? offs_word : offs_hold;
      gain_nxt = gain_load ? gain_word : gain_hold;
      gain_lim = GAIN_W'(clamp_gain(32'(gain_nxt), UNITY));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         freq_hold <= '0;
         offs_hold <= '0;
         gain_hold <= '0;
         freq_act  <= '0;
         offs_act  <= '0;
         gain_act  <= '0;
      end else begin
         freq_hold <= freq_nxt;
         offs_hold <= offs_nxt;
         gain_hold <= gain_nxt;
         if (commit) begin
            freq_act <= freq_nxt;
            offs_act <= offs_nxt;
            gain_act <= gain_lim;
         end
      end
   end

   // R2: working settings move only on a commit
   a_r2_freq_hold: assert property (@(posedge clk) disable iff (rst)
      !$past(commit) |-> $stable(freq_act));
   a_r2_offs_hold: assert property (@(posedge clk) disable iff (rst)
      !$past(commit) |-> $stable(offs_act));
   // R5: working gain never exceeds unity
   a_r5_gain_cap: assert property (@(posedge clk) disable iff (rst)
      32'(gain_act) <= 32'(UNITY));

endmodule

// File: rtl/nco_phase.sv
module nco_phase #(
   parameter int ACC_W = 32,
   parameter int OFS_W = 14,
   parameter int PHS_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             phase_zero,
   input  logic [ACC_W-1:0] freq_act,
   input  logic [OFS_W-1:0] offs_act,
   output logic [PHS_W-1:0] phase_q
);
   logic [ACC_W-1:0] acc;
   logic [OFS_W-1:0] offs_sum;

   generate
      if (OFS_W > ACC_W) begin : g_bad_ofs
         $error("offset wider than accumulator");
      end
      if (PHS_W > OFS_W || PHS_W < 3) begin : g_bad_phs
         $error("table phase width out of range");
      end
   endgenerate

   always_comb offs_sum = acc[ACC_W-1 -: OFS_W] + offs_act;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc     <= '0;
         phase_q <= '0;
      end else begin
         acc     <= phase_zero ? '0 : acc + freq_act;
         phase_q <= offs_sum[OFS_W-1 -: PHS_W];
      end
   end

   // R1: modular step by the working word
   a_r1_acc_step: assert property (@(posedge clk) disable iff (rst)
      !$past(phase_zero) |-> acc == $past(acc) + $past(freq_act));
   // R7: phase zero clears the accumulator
   a_r7_zero: assert property (@(posedge clk) disable iff (rst)
      $past(phase_zero) |-> acc == '0);

endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
   parameter int PHS_W = 12,
   parameter int AMP_W = 10
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [PHS_W-1:0]        phase_q,
   output logic signed [AMP_W-1:0] sample
);
   import nco_pkg::*;

   localparam int AW    = PHS_W - 2;
   localparam int DEPTH = 1 << AW;
   localparam int MW    = AMP_W - 1;

   logic [MW-1:0] table_q [DEPTH];
   logic [AW-1:0] idx, addr;
   logic [1:0]    quad;
   logic [MW-1:0] mag_q;
   logic          neg_q;

   generate
      if (AMP_W < 2) begin : g_bad_amp
         $error("amplitude width too small");
      end
      for (genvar i = 0; i < DEPTH; i++) begin : g_rom
         assign table_q[i] = MW'(qsine(i, AW, MW));
      end
   endgenerate

   always_comb begin
      quad = phase_q[PHS_W-1 -: 2];
      idx  = phase_q[AW-1:0];
      addr = quad[0] ? ~idx : idx;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mag_q <= '0;
         neg_q <= 1'b0;
      end else begin
         mag_q <= table_q[addr];
         neg_q <= quad[1];
      end
   end

   always_comb sample = neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});

endmodule

// File: rtl/nco_scale.sv
module nco_scale #(
   parameter int AMP_W = 10,
   parameter int GAIN_W = 10
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [AMP_W-1:0] sample,
   input  logic [GAIN_W-1:0]       gain,
   output logic signed [AMP_W-1:0] dac_out
);
   localparam int PW = AMP_W + GAIN_W + 1;

   logic signed [PW-1:0] prod, shifted;

   always_comb begin
      prod    = PW'(sample) * $signed({1'b0, gain});
      shifted = prod >>> (GAIN_W - 1);
   end

   always_ff @(posedge clk) begin
      if (rst) dac_out <= '0;
      else     dac_out <= shifted[AMP_W-1:0];
   end

endmodule

// File: rtl/nco_core.sv
module nco_core #(
   parameter int ACC_W  = 32,
   parameter int OFS_W  = 14,
   parameter int PHS_W  = 12,
   parameter int AMP_W  = 10,
   parameter int GAIN_W = 10
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    freq_load,
   input  logic [ACC_W-1:0]        freq_word,
   input  logic                    offs_load,
   input  logic [OFS_W-1:0]        offs_word,
   input  logic                    gain_load,
   input  logic [GAIN_W-1:0]       gain_word,
   input  logic                    commit,
   input  logic                    phase_zero,
   output logic signed [AMP_W-1:0] dac_out
);
   logic [ACC_W-1:0]        freq_act;
   logic [OFS_W-1:0]        offs_act;
   logic [GAIN_W-1:0]       gain_act, gain_p1, gain_p2;
   logic [PHS_W-1:0]        phase_q;
   logic signed [AMP_W-1:0] sample;

   nco_ctrl #(.ACC_W(ACC_W), .OFS_W(OFS_W), .GAIN_W(GAIN_W)) u_ctrl (
      .clk(clk), .rst(rst),
      .freq_load(freq_load), .freq_word(freq_word),
      .offs_load(offs_load), .offs_word(offs_word),
      .gain_load(gain_load), .gain_word(gain_word),
      .commit(commit),
      .freq_act(freq_act), .offs_act(offs_act), .gain_act(gain_act)
   );

   nco_phase #(.ACC_W(ACC_W), .OFS_W(OFS_W), .PHS_W(PHS_W)) u_phase (
      .clk(clk), .rst(rst), .phase_zero(phase_zero),
      .freq_act(freq_act), .offs_act(offs_act), .phase_q(phase_q)
   );

   nco_sine_lut #(.PHS_W(PHS_W), .AMP_W(AMP_W)) u_lut (
      .clk(clk), .rst(rst), .phase_q(phase_q), .sample(sample)
   );

   // gain travels alongside the phase so offset and gain land together
   always_ff @(posedge clk) begin
      if (rst) begin
         gain_p1 <= '0;
         gain_p2 <= '0;
      end else begin
         gain_p1 <= gain_act;
         gain_p2 <= gain_p1;
      end
   end

   nco_scale #(.AMP_W(AMP_W), .GAIN_W(GAIN_W)) u_scale (
      .clk(clk), .rst(rst), .sample(sample), .gain(gain_p2), .dac_out(dac_out)
   );

   // R4: output sign follows the quadrant two stages back
   a_r4_neg_half: assert property (@(posedge clk) disable iff (rst)
      $past(phase_q[PHS_W-1], 2) |-> dac_out <= 0);
   a_r4_pos_half: assert property (@(posedge clk) disable iff (rst)
      !$past(phase_q[PHS_W-1], 2) |-> dac_out >= 0);
   // R6: output is zero right after reset
   a_r6_reset_zero: assert property (@(posedge clk)
      $past(rst) |-> dac_out == '0);

endmodule

// File: tb/nco_core_tb.sv
`timescale 1ns/1ps
module nco_core_tb;
   localparam real PI = 3.14159265358979;

   logic              clk = 0;
   logic              rst = 1;
   logic              freq_load = 0, offs_load = 0, gain_load = 0, commit = 0, phase_zero = 0;
   logic [31:0]       freq_word = 0;
   logic [13:0]       offs_word = 0;
   logic [9:0]        gain_word = 0;
   logic signed [9:0] dac_out;

   int checks = 0, fails = 0;
   bit model_on = 0;
   string cur_req = "R6";

   // bench model
   logic [31:0] m_acc = 0, m_fa = 0, m_fh = 0;
   logic [13:0] m_oa = 0, m_oh = 0;
   logic [9:0]  m_ga = 0, m_gh = 0;
   logic [31:0] h_acc [4];
   logic [13:0] h_ofs [4];
   logic [9:0]  h_gn  [4];

   always #4 clk = ~clk;

   nco_core u_dut (
      .clk(clk), .rst(rst),
      .freq_load(freq_load), .freq_word(freq_word),
      .offs_load(offs_load), .offs_word(offs_word),
      .gain_load(gain_load), .gain_word(gain_word),
      .commit(commit), .phase_zero(phase_zero), .dac_out(dac_out)
   );

   function automatic int expect_out(logic [31:0] acc, logic [13:0] ofs, logic [9:0] g);
      logic [13:0] s;
      logic [11:0] ph;
      int a, m, smp, p;
      s  = acc[31:18] + ofs;
      ph = s[13:2];
      a  = ph[10] ? 1023 - int'(ph[9:0]) : int'(ph[9:0]);
      m  = $rtoi(511.0 * $sin(PI / 2.0 * (real'(a) + 0.5) / 1024.0) + 0.5);
      smp = ph[11] ? -m : m;
      p   = smp * int'(g);
      return (p >= 0) ? p / 512 : -((-p + 511) / 512);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      logic [9:0] gnew;
      if (rst) begin
         m_acc = 0; m_fa = 0; m_fh = 0; m_oa = 0; m_oh = 0; m_ga = 0; m_gh = 0;
      end else begin
         m_acc = phase_zero ? 32'd0 : m_acc + m_fa;
         if (commit) begin
            m_fa = freq_load ? freq_word : m_fh;
            m_oa = offs_load ? offs_word : m_oh;
            gnew = gain_load ? gain_word : m_gh;
            m_ga = (gnew > 10'd512) ? 10'd512 : gnew;
         end
         if (freq_load) m_fh = freq_word;
         if (offs_load) m_oh = offs_word;
         if (gain_load) m_gh = gain_word;
      end
      for (int i = 3; i > 0; i--) begin
         h_acc[i] = h_acc[i-1]; h_ofs[i] = h_ofs[i-1]; h_gn[i] = h_gn[i-1];
      end
      h_acc[0] = m_acc; h_ofs[0] = m_oa; h_gn[0] = m_ga;
   end

   always @(negedge clk) begin
      if (model_on) begin
         int e, d;
         e = expect_out(h_acc[3], h_ofs[3], h_gn[3]);
         d = int'(dac_out) - e;
         check(d <= 2 && d >= -2, cur_req, int'(dac_out), e);
      end
   end

   // one-cycle drive of loads and commit, starting at a negedge
   task automatic drive(input bit lf, input logic [31:0] f, input bit lo, input logic [13:0] o,
                        input bit lg, input logic [9:0] g, input bit cm);
      freq_load = lf; freq_word = f; offs_load = lo; offs_word = o;
      gain_load = lg; gain_word = g; commit = cm;
      @(negedge clk);
      freq_load = 0; offs_load = 0; gain_load = 0; commit = 0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drive at a negedge, return edges from commit edge to first output change
   task automatic latency(input bit lf, input logic [31:0] f, input bit lo, input logic [13:0] o,
                          input bit lg, input logic [9:0] g, output int lat);
      logic signed [9:0] base;
      base = dac_out;
      lat = -1;
      freq_load = lf; freq_word = f; offs_load = lo; offs_word = o;
      gain_load = lg; gain_word = g; commit = 1;
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         freq_load = 0; offs_load = 0; gain_load = 0; commit = 0;
         if (dac_out != base && lat < 0) lat = k - 1;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      int lat;
      logic signed [9:0] cap [160];
      settle(3);
      // R6: reset state
      check(dac_out == 0, "R6", int'(dac_out), 0);
      rst = 0;
      settle(4);
      check(dac_out == 0, "R6", int'(dac_out), 0);
      model_on = 1;

      // R5 unity gain, zero phase
      cur_req = "R5";
      drive(1, 0, 1, 0, 1, 10'd512, 1);
      settle(6);

      // R4/R3: sweep every table phase via the offset, with offset low bits varied
      cur_req = "R4";
      for (int i = 0; i < 4096; i++) begin
         drive(0, 0, 1, 14'((i << 2) | (i & 3)), 0, 0, 1);
      end
      settle(4);
      cur_req = "R3";
      drive(1, 32'h0001_0000, 1, 14'h0003, 0, 0, 1);
      settle(600);

      // R8: latencies
      cur_req = "R8";
      drive(1, 0, 1, 0, 0, 0, 1);
      drive(0, 0, 0, 0, 0, 0, 0);
      phase_zero = 1; @(negedge clk); phase_zero = 0;
      settle(6);
      latency(1, 32'h0040_0000, 0, 0, 0, 0, lat);
      check(lat == 4, "R8", lat, 4);
      drive(1, 0, 0, 0, 0, 0, 1);
      settle(6);
      latency(0, 0, 1, 14'h0800, 0, 0, lat);
      check(lat == 3, "R8", lat, 3);
      settle(4);
      latency(0, 0, 0, 0, 1, 10'd256, lat);
      check(lat == 3, "R8", lat, 3);
      settle(4);

      // R2: loads without commit change nothing
      cur_req = "R2";
      drive(1, 32'h1234_5678, 1, 14'h1555, 1, 10'd77, 0);
      begin
         logic signed [9:0] held;
         held = dac_out;
         settle(12);
         check(dac_out == held, "R2", int'(dac_out), int'(held));
      end
      drive(0, 0, 0, 0, 0, 0, 1);
      settle(300);

      // R7: zeroing keeps offset and gain
      cur_req = "R7";
      drive(1, 0, 1, 14'h1000, 1, 10'd512, 1);
      settle(3);
      phase_zero = 1; @(negedge clk); phase_zero = 0;
      settle(5);
      check(dac_out >= 509, "R7", int'(dac_out), 511);
      drive(1, 32'h0300_0000, 0, 0, 0, 0, 1);
      settle(20);
      phase_zero = 1; @(negedge clk); phase_zero = 0;
      settle(20);

      // R1: wrap with large words
      cur_req = "R1";
      drive(1, 32'hC000_0001, 1, 0, 0, 0, 1);
      settle(200);
      drive(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 1);
      settle(200);
      drive(1, 32'h7654_3211, 0, 0, 0, 0, 1);
      settle(200);

      // R5: gain values incl. zero and above unity
      cur_req = "R5";
      drive(1, 32'h0123_4567, 0, 0, 1, 10'd0, 1);
      settle(50);
      check(dac_out == 0, "R5", int'(dac_out), 0);
      drive(0, 0, 0, 0, 1, 10'd1, 1);   settle(100);
      drive(0, 0, 0, 0, 1, 10'd300, 1); settle(100);
      drive(0, 0, 0, 0, 1, 10'd1023, 1); settle(100);
      drive(0, 0, 0, 0, 1, 10'd513, 1); settle(100);

      // R9: power-of-two word gives exact period
      cur_req = "R9";
      drive(1, 32'h0400_0000, 1, 0, 1, 10'd512, 1);
      phase_zero = 1; @(negedge clk); phase_zero = 0;
      settle(8);
      for (int i = 0; i < 160; i++) begin
         cap[i] = dac_out;
         @(negedge clk);
      end
      for (int i = 0; i < 96; i++) begin
         check(cap[i+64] == cap[i], "R9", int'(cap[i+64]), int'(cap[i]));
         check(cap[i+32] == -cap[i], "R9", int'(cap[i+32]), -int'(cap[i]));
      end

      // R6: reset mid-run
      cur_req = "R6";
      model_on = 0;
      rst = 1;
      settle(3);
      check(dac_out == 0, "R6", int'(dac_out), 0);
      rst = 0;
      settle(6);
      check(dac_out == 0, "R6", int'(dac_out), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule